// File: doc/BRIEF.md
# CAN Controller Sleep and Wakeup Sequencer

This block supervises the low-power state of a CAN protocol controller. Software puts the controller to sleep by writing a sleep code into a two-bit power-save field. The block accepts that code only while the bus is idle. While the controller sleeps, a falling edge on the receive line is a wakeup event. A falling edge is a change from recessive (1) to dominant (0), and the line passes through a synchroniser before the block looks for edges.

A wakeup event sets a sticky wakeup flag and gives a one-cycle interrupt pulse at once. The controller does not go back to synchronous operation at that point. It first enters a dead-time window. That window ends on the next falling edge of the receive line, or when software writes the normal code into the power-save field. During the window the field still reads back the sleep code, so software can poll it. Writes to the configuration register and clears of the wakeup flag are discarded during the window.

When the controller clock is reported as stopped, the wakeup edge returns the block directly to normal operation with no dead time. A transceiver that holds the line dominant after its single wakeup edge leaves the block in the dead time until software ends it.

Top module: `can_slp_seq`

## Requirements
- R1: After reset the block is in normal operation: `awake_o`=1, the mode register (address 0) reads 0, the status register (address 1) reads 0, the configuration register (address 2) reads 0 and `wake_irq_o`=0.
- R2: Writing power-save code 2'b01 to bits [1:0] of address 0 while in normal operation enters sleep on the next clock, but only if the synchronised receive line is recessive. If the line is dominant, the write is ignored and the mode register stays 0. In sleep the mode register reads 1 and `awake_o`=0.
- R3: In sleep, a recessive-to-dominant transition on `rx_i` raises a wakeup event. The transition is seen after a two-flop synchroniser, and the state changes on the third rising clock edge after `rx_i` falls. The event sets status bit 5 and pulses `wake_irq_o` for one cycle. The block then enters the dead time: the mode register still reads 1 and `awake_o` stays 0.
- R4: In the dead time, a further recessive-to-dominant transition returns the block to normal operation: the mode register reads 0 and `awake_o`=1. A dominant-to-recessive transition has no effect.
- R5: Writing code 2'b00 to address 0 during sleep or the dead time returns the block to normal operation on the next clock. If that write arrives in the same cycle as a sleep wakeup edge, the write wins: the block goes to normal operation, no wakeup flag is set and no pulse is given.
- R6: A write to the configuration register (address 2) takes effect only in normal operation. Writes made in sleep or during the dead time are discarded.
- R7: Writing 1 to bit 5 of address 1 clears the wakeup flag only in normal operation. During the dead time the clear is ignored and the flag stays 1.
- R8: While the wakeup flag is still set, a new wakeup event moves the state as usual but gives no new `wake_irq_o` pulse.
- R9: With `clk_stop_i`=1, a wakeup edge in sleep returns the block straight to normal operation with no dead time, and still sets the flag and gives the pulse.
- R10: If `rx_i` stays dominant after the first wakeup edge, the block stays in the dead time for as long as the line is held. Only a software write of 2'b00 ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous CAN receive line, 1 = recessive |
| clk_stop_i | input | 1 | Controller clock is stopped while asleep |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for both read and write |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| wake_irq_o | output | 1 | One-cycle wakeup interrupt pulse |
| awake_o | output | 1 | Controller is in normal synchronous operation |

## Verification
The hardest situation to reach is a software mode-clear write that lands in exactly the same clock cycle as a synchronised wakeup edge. The bench reaches it by counting the two synchroniser stages: it lowers `rx_i` away from a clock edge, waits two rising edges, and then presents the write so that both are sampled on the third edge. The dead time is held open on purpose, either by keeping `rx_i` recessive between edges or by keeping it dominant for hundreds of cycles. That lets the bench try configuration writes and flag clears inside the window and read them back afterwards.

// File: rtl/can_slp_pkg.sv
// Package: shared types and constants of the sleep/wakeup sequencer.
// Assumes register addresses fit in the top-level ADDR_W parameter.
package can_slp_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_DEAD   = 2'd2
    } slp_state_t;

    localparam logic [1:0] PSM_NORMAL = 2'b00;
    localparam logic [1:0] PSM_SLEEP  = 2'b01;

    localparam int ADDR_MODE = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CFG  = 2;
    localparam int WAKE_BIT  = 5;
endpackage

// File: rtl/slp_rx_edge.sv
// Module: synchronises the receive line and flags recessive-to-dominant edges.
// Assumes rx_i is asynchronous; all stages reset to recessive so no false edge appears.
module slp_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_level_o,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the raw line through the synchroniser chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[LAST-1:0], rx_i};
            end
        end
    endgenerate

    // Keep the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    assign rx_level_o = sync_q[LAST];
    assign fall_o     = prev_q & ~sync_q[LAST];

    // R3: an edge pulse never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o) else $error("edge pulse stretched");
endmodule

// File: rtl/slp_fsm.sv
// Module: sleep / dead-time / normal state machine with the sticky wakeup flag.
// Assumes request inputs are single-cycle decoded register writes.
module slp_fsm
    import can_slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       bus_idle_i,
    input  logic       clk_stop_i,
    input  logic       sleep_req_i,
    input  logic       wake_req_i,
    input  logic       clr_req_i,
    output slp_state_t state_o,
    output logic       flag_o,
    output logic       irq_o
);
    slp_state_t state_q;
    logic       flag_q;
    logic       irq_q;

    // Advance the state, set or clear the flag, and form the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                ST_NORMAL: begin
                    if (sleep_req_i && bus_idle_i) state_q <= ST_SLEEP;
                    if (clr_req_i) flag_q <= 1'b0;
                end
                ST_SLEEP: begin
                    if (wake_req_i) begin
                        state_q <= ST_NORMAL;
                    end else if (fall_i) begin
                        state_q <= clk_stop_i ? ST_NORMAL : ST_DEAD;
                        if (!flag_q) begin
                            flag_q <= 1'b1;
                            irq_q  <= 1'b1;
                        end
                    end
                end
                ST_DEAD: begin
                    if (wake_req_i || fall_i) state_q <= ST_NORMAL;
                end
                default: state_q <= ST_NORMAL;
            endcase
        end
    end

    assign state_o = state_q;
    assign flag_o  = flag_q;
    assign irq_o   = irq_q;

    // R3: a wakeup edge without a stopped clock lands in the dead time with the flag set
    a_r3_wake_to_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && fall_i && !wake_req_i && !clk_stop_i)
        |=> (state_q == ST_DEAD && flag_q)) else $error("wake edge missed");
    // R4: the dead time is never entered from normal operation
    a_r4_no_direct_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL) |=> (state_q != ST_DEAD)) else $error("bad dead entry");
    // R5: a software exit wins over everything else in sleep or dead time
    a_r5_soft_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORMAL && wake_req_i) |=> (state_q == ST_NORMAL))
        else $error("soft exit lost");
    // R7: a flag clear during the dead time is ignored
    a_r7_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEAD && flag_q) |=> flag_q) else $error("flag cleared in dead time");
    // R8: no pulse while the flag is already set
    a_r8_no_repeat_irq: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> !irq_q) else $error("repeat interrupt");
    // R9: with the clock stopped, a wake edge goes straight to normal
    a_r9_no_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && fall_i && clk_stop_i) |=> (state_q == ST_NORMAL))
        else $error("dead time with stopped clock");
endmodule

// File: rtl/slp_regs.sv
// Module: register decode, readback and dead-time write gating.
// Assumes DATA_W > WAKE_BIT; reads are combinational on addr_i.
module slp_regs
    import can_slp_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  slp_state_t        state_i,
    input  logic              flag_i,
    output logic              sleep_req_o,
    output logic              wake_req_o,
    output logic              clr_req_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);

    logic [DATA_W-1:0] cfg_q;
    logic              awake;
    logic [1:0]        psm;

    assign awake = (state_i == ST_NORMAL);
    assign psm   = awake ? PSM_NORMAL : PSM_SLEEP;

    // Decode mode and status writes into requests for the state machine.
    always_comb begin
        sleep_req_o = wr_en_i && (addr_i == A_MODE) && (wdata_i[1:0] == PSM_SLEEP);
        wake_req_o  = wr_en_i && (addr_i == A_MODE) && (wdata_i[1:0] == PSM_NORMAL);
        clr_req_o   = wr_en_i && (addr_i == A_STAT) && wdata_i[WAKE_BIT];
    end

    // Hold the configuration register; writes land only in normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cfg_q <= '0;
        else if (wr_en_i && addr_i == A_CFG && awake) cfg_q <= wdata_i;
    end

    // Select the read data for the current address.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_MODE)      rdata_o[1:0]     = psm;
        else if (addr_i == A_STAT) rdata_o[WAKE_BIT] = flag_i;
        else if (addr_i == A_CFG)  rdata_o          = cfg_q;
    end

    // R6: the configuration register cannot change outside normal operation
    a_r6_cfg_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> $stable(cfg_q)) else $error("cfg written while asleep");
endmodule

// File: rtl/can_slp_seq.sv
// Module: top of the CAN sleep/wakeup sequencer.
// Assumes a single clock domain apart from the asynchronous rx_i input.
module can_slp_seq
    import can_slp_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              clk_stop_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wake_irq_o,
    output logic              awake_o
);
    logic       rx_level;
    logic       fall;
    logic       sleep_req;
    logic       wake_req;
    logic       clr_req;
    logic       flag;
    slp_state_t state;

    slp_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .rx_level_o(rx_level), .fall_o(fall)
    );

    slp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .bus_idle_i(rx_level),
        .clk_stop_i(clk_stop_i), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
        .clr_req_i(clr_req), .state_o(state), .flag_o(flag), .irq_o(wake_irq_o)
    );

    slp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .state_i(state), .flag_i(flag),
        .sleep_req_o(sleep_req), .wake_req_o(wake_req), .clr_req_o(clr_req),
        .rdata_o(rdata_o)
    );

    assign awake_o = (state == ST_NORMAL);

    // R2: sleep is never entered while the bus is dominant
    a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && !rx_level) |=> awake_o) else $error("sleep entered on busy bus");
endmodule

// File: tb/can_slp_seq_bench.sv
`timescale 1ns/1ps
module can_slp_seq_bench;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_i = 1'b1;
    logic              clk_stop_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              wake_irq_o;
    logic              awake_o;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;

    always #10 clk = ~clk;

    can_slp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_can_slp_seq (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .clk_stop_i(clk_stop_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .wake_irq_o(wake_irq_o), .awake_o(awake_o)
    );

    always @(posedge clk) if (wake_irq_o) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = DATA_W'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr_i = ADDR_W'(a);
        #1;
        d = int'(rdata_o);
    endtask

    // Drive a falling edge on rx and wait until the state has reacted.
    task automatic fall_edge();
        @(negedge clk); rx_i = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic rise_edge();
        @(negedge clk); rx_i = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        int d;
        rd(0, d); check("R1 mode", d, 0);
        rd(1, d); check("R1 status", d, 0);
        rd(2, d); check("R1 cfg", d, 0);
        check("R1 awake", awake_o, 1);
        check("R1 irq", wake_irq_o, 0);
    endtask

    task automatic t_busy_entry();
        int d;
        fall_edge();
        wr(0, 1);
        rd(0, d); check("R2 busy bus ignored", d, 0);
        rise_edge();
        check("R4 rising edge no effect", awake_o, 1);
    endtask

    task automatic t_two_edges();
        int d;
        int base;
        base = irq_cnt;
        wr(0, 1);
        rd(0, d); check("R2 sleep entry", d, 1);
        check("R2 awake low", awake_o, 0);
        wr(2, 8'h3C);
        rd(2, d); check("R6 cfg write in sleep", d, 0);
        fall_edge();
        rd(1, d); check("R3 flag set", d, 32);
        rd(0, d); check("R3 still sleep code", d, 1);
        check("R3 dead awake", awake_o, 0);
        check("R3 one pulse", irq_cnt - base, 1);
        wr(2, 8'hA5);
        rd(2, d); check("R6 cfg write in dead time", d, 0);
        wr(1, 32);
        rd(1, d); check("R7 clear ignored in dead time", d, 32);
        rise_edge();
        rd(0, d); check("R4 rising edge keeps dead", d, 1);
        fall_edge();
        rd(0, d); check("R4 second edge exits", d, 0);
        check("R4 awake", awake_o, 1);
        wr(1, 32);
        rd(1, d); check("R7 clear in normal", d, 0);
        wr(2, 8'hA5);
        rd(2, d); check("R6 cfg write in normal", d, 165);
        rise_edge();
    endtask

    task automatic t_soft_exit();
        int d;
        wr(0, 1);
        fall_edge();
        rd(0, d); check("R5 in dead time", d, 1);
        wr(0, 0);
        rd(0, d); check("R5 soft exit", d, 0);
        check("R5 awake", awake_o, 1);
        wr(1, 32);
        rise_edge();
        wr(0, 1);
        wr(0, 0);
        rd(0, d); check("R5 soft exit from sleep", d, 0);
    endtask

    task automatic t_priority();
        int d;
        int base;
        base = irq_cnt;
        wr(0, 1);
        @(negedge clk); rx_i = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h00;
        @(posedge clk);
        @(negedge clk); wr_en_i = 1'b0;
        repeat (2) @(posedge clk);
        rd(0, d); check("R5 write wins mode", d, 0);
        rd(1, d); check("R5 write wins no flag", d, 0);
        check("R5 write wins no pulse", irq_cnt - base, 0);
        rise_edge();
    endtask

    task automatic t_sticky();
        int d;
        int base;
        wr(0, 1);
        fall_edge();
        rise_edge();
        fall_edge();
        rise_edge();
        base = irq_cnt;
        wr(0, 1);
        fall_edge();
        rd(0, d); check("R8 state advances", d, 1);
        rd(1, d); check("R8 flag held", d, 32);
        check("R8 no new pulse", irq_cnt - base, 0);
        wr(0, 0);
        wr(1, 32);
        rise_edge();
    endtask

    task automatic t_clk_stop();
        int d;
        int base;
        base = irq_cnt;
        @(negedge clk); clk_stop_i = 1'b1;
        wr(0, 1);
        fall_edge();
        rd(0, d); check("R9 direct exit", d, 0);
        check("R9 awake", awake_o, 1);
        rd(1, d); check("R9 flag", d, 32);
        check("R9 pulse", irq_cnt - base, 1);
        @(negedge clk); clk_stop_i = 1'b0;
        wr(1, 32);
        rise_edge();
    endtask

    task automatic t_stuck();
        int d;
        wr(0, 1);
        fall_edge();
        repeat (300) @(posedge clk);
        rd(0, d); check("R10 held dominant stays dead", d, 1);
        check("R10 awake low", awake_o, 0);
        wr(0, 0);
        rd(0, d); check("R10 software exit", d, 0);
        wr(1, 32);
        rise_edge();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_busy_entry();
        t_two_edges();
        t_soft_exit();
        t_priority();
        t_sticky();
        t_clk_stop();
        t_stuck();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule